// File: doc/BRIEF.md
# EEPROM Page Buffer and Write-Cycle Sequencer

This block sits between the serial protocol engine of a byte-addressed EEPROM and its storage array. The engine hands it each received data byte of a write transaction, together with the word address that the transaction set up. The block gathers these bytes in a one-page staging buffer, which is 64 bytes by default. Only the low offset bits of its write pointer advance, so a long burst stays inside one page and wraps over bytes it stored earlier. A per-entry valid mask records which buffer slots were actually filled.

When the engine reports the end of the transaction, the block samples the write-protect input once. If protection is active, the staged bytes are discarded and the block is ready again on the next cycle. Otherwise it runs a self-timed commit of a parameterized number of clock cycles. During the first page-size cycles of the commit, it writes the filled entries to the array in ascending offset order. For the whole commit it holds `busy` high so the engine can withhold acknowledges.

The controller has three states:
- ST_IDLE: the buffer is empty.
- ST_FILL: at least one byte is staged.
- ST_COMMIT: the timed write is running.

Its transitions are:
- IDLE to FILL on an accepted load.
- FILL to COMMIT on STOP with protection off.
- FILL to IDLE on STOP with protection on.
- COMMIT to IDLE when the timer reaches its last cycle.

Top module: `eeprom_page_commit`

## Requirements
- R1: On the first accepted load of a transaction, the byte is staged at offset `ld_addr[5:0]` of the page `ld_addr[14:6]`. Afterwards `ptr_out` reads that address plus one within the page.
- R2: Each further load is staged at the current `ptr_out` offset. Only `ptr_out[5:0]` advances, wrapping from 63 to 0, and `ptr_out[14:6]` stays unchanged.
- R3: If more than 64 bytes are loaded before STOP, a later byte replaces the earlier byte at the same offset, and only the latest value is committed.
- R4: A STOP with no staged byte starts nothing: `busy` stays 0 and `mem_we` stays 0.
- R5: A STOP with staged bytes and `wp_in`=0 raises `busy` in the cycle after the STOP. `busy` stays high for exactly `WC_CYCLES` cycles.
- R6: During a commit, `mem_we` pulses once for each filled entry and for no other. The pulses come in ascending offset order, with `mem_addr` = {page, offset} and `mem_wdata` = the staged byte, and only while `busy` is high.
- R7: A STOP with staged bytes and `wp_in`=1 discards them. No write occurs, `busy` stays 0, and a new load is accepted on the next cycle.
- R8: Changing `wp_in` while a commit runs does not alter its writes or its length.
- R9: Loads and STOPs that arrive while `busy` is high are ignored. They change neither `ptr_out` nor the staged data.
- R10: After a commit or a discard, the buffer is empty, so the next transaction commits only its own bytes.
- R11: During and right after reset, `busy`=0, `mem_we`=0 and `ptr_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | One-cycle strobe: a data byte was received |
| ld_addr | input | ADDR_W | Word address; used on the first byte of a transaction |
| ld_data | input | DATA_W | Received data byte |
| stop_strobe | input | 1 | One-cycle strobe: the transaction ended with STOP |
| wp_in | input | 1 | Write protect, sampled with `stop_strobe` |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Commit in progress |
| ptr_out | output | ADDR_W | Address following the last staged byte |

## Verification
The bench targets several corner cases:
- A burst that starts at offset 62 and crosses the page end. A design that carried into the page bits would write to the next page.
- A 70-byte burst. A design that appended past 64 entries, or kept the first value instead of the latest, would produce the wrong set of writes.
- An empty STOP and a protected STOP. A design that ran an unneeded cycle would raise `busy`, and one that leaked data would write to the array.
- Loads, a STOP and a toggle of `wp_in` in the middle of a commit. A design that let these through would move the pointer, cut the cycle short, or stage ghost bytes that a later STOP would commit.

// File: rtl/eeprom_pc_pkg.sv
package eeprom_pc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_COMMIT = 2'd2
    } pc_state_t;
endpackage

// File: rtl/epc_page_buf.sv
module epc_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_ofs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);
    localparam int DEPTH = 1 << OFS_W;

    logic [DATA_W-1:0] slot [DEPTH];
    logic [DEPTH-1:0]  vmask;

    always_ff @(posedge clk) begin
        if (wr_en) slot[wr_ofs] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vmask <= '0;
        else if (clr)   vmask <= '0;
        else if (wr_en) vmask[wr_ofs] <= 1'b1;
    end

    always_comb begin
        rd_data   = slot[rd_ofs];
        rd_valid  = vmask[rd_ofs];
        any_valid = |vmask;
    end

    // R10: a clear leaves nothing staged
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !any_valid);
    // R3: a staged entry is marked filled afterwards
    a_r3_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> vmask[$past(wr_ofs)]);
endmodule

// File: rtl/epc_cycle_timer.sv
module epc_cycle_timer #(
    parameter int CYCLES = 250000,
    localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!en) cnt <= '0;
        else if (!last) cnt <= cnt + 1'b1;
        else          cnt <= '0;
    end

    assign last = en && (cnt == CNT_W'(CYCLES - 1));

    // R5: the count advances by one each running cycle
    a_r5_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !last) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
    import eeprom_pc_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int WC_CYCLES  = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              stop_strobe,
    input  logic              wp_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr_out
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFS_W;
    localparam int CNT_W  = (WC_CYCLES > 2) ? $clog2(WC_CYCLES) : 1;

    pc_state_t         state, state_nx;
    logic [BASE_W-1:0] base_q;
    logic [OFS_W-1:0]  ofs_q, wr_ofs, rd_ofs;
    logic              accept, first, any_valid, clr;
    logic              rd_valid, tmr_last, in_window;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]  tmr_cnt;

    assign accept = ld_valid && !stop_strobe && (state != ST_COMMIT);
    assign first  = !any_valid;
    assign wr_ofs = first ? ld_addr[OFS_W-1:0] : ofs_q;
    assign clr    = ((state == ST_FILL) && stop_strobe && wp_in) || tmr_last;
    assign rd_ofs = tmr_cnt[OFS_W-1:0];

    epc_page_buf #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_ofs(wr_ofs), .wr_data(ld_data),
        .clr(clr), .rd_ofs(rd_ofs),
        .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
    );

    epc_cycle_timer #(.CYCLES(WC_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .en(state == ST_COMMIT), .cnt(tmr_cnt), .last(tmr_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_FILL;
            ST_FILL:   if (stop_strobe) state_nx = wp_in ? ST_IDLE : ST_COMMIT;
            ST_COMMIT: if (tmr_last) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // address pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ofs_q  <= '0;
        end else if (accept) begin
            if (first) base_q <= ld_addr[ADDR_W-1:OFS_W];
            ofs_q <= wr_ofs + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state == ST_COMMIT);
        in_window = (32'(tmr_cnt) < PAGE_BYTES);
        mem_we    = busy && in_window && rd_valid;
        mem_addr  = {base_q, rd_ofs};
        mem_wdata = rd_data;
        ptr_out   = {base_q, ofs_q};
    end

    // R6: no array write outside a commit
    a_r6_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
    // R5: a commit begins only after an unprotected STOP
    a_r5_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(stop_strobe) && !$past(wp_in)));
    // R4: an empty STOP starts nothing
    a_r4_empty_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_strobe && state == ST_IDLE) |=> !busy);
    // R7: a protected STOP drops straight back to idle
    a_r7_protected_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_strobe && state == ST_FILL && wp_in) |=> (!busy && state == ST_IDLE));
    // R2: the page bits hold after the first byte
    a_r2_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && any_valid) |=> $stable(ptr_out[ADDR_W-1:OFS_W]));
    // R9: the pointer is frozen through a commit
    a_r9_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ptr_out));
    // R10: idle means an empty buffer
    a_r10_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !any_valid);
endmodule

// File: tb/eeprom_page_commit_tb.sv
module eeprom_page_commit_tb;
    localparam int AW = 15, DW = 8, PB = 64, WC = 100;

    logic clk = 0, rst_n = 0;
    logic ld_valid = 0, stop_strobe = 0, wp_in = 0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic mem_we, busy;
    logic [AW-1:0] mem_addr, ptr_out;
    logic [DW-1:0] mem_wdata;

    always #10 clk = ~clk;

    eeprom_page_commit #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WC_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_data(ld_data), .stop_strobe(stop_strobe), .wp_in(wp_in),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .ptr_out(ptr_out));

    int n_chk = 0, n_bad = 0;
    string cur_tag = "R6";
    logic [AW+DW-1:0] exp_q[$];

    // reference model
    logic [DW-1:0] m_buf [PB];
    logic [PB-1:0] m_mask = '0;
    logic [8:0]    m_base = '0;
    logic [5:0]    m_ofs = '0;

    int busy_run = 0, last_len = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor and busy-length tracker
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) check(0, cur_tag, {mem_addr, mem_wdata}, 0);
            else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                check({mem_addr, mem_wdata} == e, cur_tag, {mem_addr, mem_wdata}, e);
            end
        end
        if (busy) busy_run++;
        else begin
            if (busy_run != 0) last_len = busy_run;
            busy_run = 0;
        end
    end

    task automatic load_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        ld_valid = 1; ld_addr = a; ld_data = d;
        if (m_mask == '0) begin
            m_base = a[14:6];
            m_ofs  = a[5:0];
        end
        m_buf[m_ofs]  = d;
        m_mask[m_ofs] = 1'b1;
        m_ofs = m_ofs + 1'b1;
        @(negedge clk);
        ld_valid = 0;
    endtask

    task automatic stop_pulse(input bit wp, input string tag);
        bit commit;
        commit = (m_mask != '0) && !wp;
        if (commit)
            for (int i = 0; i < PB; i++)
                if (m_mask[i]) exp_q.push_back({m_base, 6'(i), m_buf[i]});
        m_mask = '0;
        @(negedge clk);
        stop_strobe = 1; wp_in = wp;
        @(negedge clk);
        stop_strobe = 0;
        check(busy == commit, tag, busy, commit);
    endtask

    task automatic wait_idle(input string tag);
        while (busy) @(negedge clk);
        @(negedge clk);
        check(last_len == WC, tag, last_len, WC);
        check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    endtask

    initial begin
        #(20 * 200000);
        check(0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && mem_we == 0 && ptr_out == 0, "R11", {busy, mem_we, ptr_out}, 0);
        rst_n = 1;
        @(negedge clk);
        check(busy == 0 && ptr_out == 0, "R11", {busy, ptr_out}, 0);

        // R1 single byte
        cur_tag = "R1";
        load_byte(15'h1234, 8'hA5);
        check(ptr_out == 15'h1235, "R1", ptr_out, 15'h1235);
        stop_pulse(0, "R5");
        wait_idle("R5");

        // R2 wrap inside the page
        cur_tag = "R2";
        for (int i = 0; i < 5; i++) load_byte(15'h0A7E, 8'h30 + 8'(i));
        check(ptr_out == 15'h0A43, "R2", ptr_out, 15'h0A43);
        stop_pulse(0, "R2");
        wait_idle("R2");

        // R3 overflow past 64
        cur_tag = "R3";
        for (int i = 0; i < 70; i++) load_byte(15'h0140, 8'(i));
        check(ptr_out == 15'h0146, "R3", ptr_out, 15'h0146);
        stop_pulse(0, "R3");
        wait_idle("R3");

        // R4 STOP with nothing staged
        cur_tag = "R4";
        stop_pulse(0, "R4");
        repeat (5) @(negedge clk);
        check(busy == 0, "R4", busy, 0);

        // R7 protected drop, then R10 next transaction alone
        cur_tag = "R7";
        for (int i = 0; i < 3; i++) load_byte(15'h2200, 8'hC0 + 8'(i));
        stop_pulse(1, "R7");
        cur_tag = "R10";
        load_byte(15'h3005, 8'h5A);
        check(ptr_out == 15'h3006, "R7", ptr_out, 15'h3006);
        stop_pulse(0, "R10");
        wait_idle("R10");

        // R8 / R9 activity during a commit
        cur_tag = "R8";
        load_byte(15'h7FFF, 8'h11);
        load_byte(15'h7FFF, 8'h22);
        stop_pulse(0, "R8");
        @(negedge clk); wp_in = 1;
        ld_valid = 1; ld_addr = 15'h0100; ld_data = 8'hEE;
        @(negedge clk); ld_valid = 0; stop_strobe = 1;
        @(negedge clk); stop_strobe = 0; wp_in = 0;
        check(busy == 1, "R9", busy, 1);
        wait_idle("R8");
        check(ptr_out == 15'h7FC1, "R9", ptr_out, 15'h7FC1);
        cur_tag = "R9";
        stop_pulse(0, "R9");
        repeat (3) @(negedge clk);
        check(busy == 0, "R9", busy, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule